// File: doc/BRIEF.md
# Valley-Switching Turn-On Timer

This block is the digital timing core of a quasi-resonant flyback PWM controller. It decides the clock edges on which the power switch turns on and off. Its inputs are an enable, the output of the sync comparator and a current-sense comparator flag. The sync comparator output already has hysteresis: it is high while the auxiliary winding is above the upper threshold and low once the winding has dropped below the lower one. The block drives a single gate-enable output. The analog comparators, the gate driver and the current sensing sit outside the block.

Every turn-on starts a new switching period. For a fixed number of cycles after that edge, no new turn-on is allowed. A bounded search window then opens. A high-to-low transition of the synchronised sync level inside the window is taken as a valley, and the switch turns on a fixed delay later. If no valley turn-on has happened by the end of the window, the switch is turned on there. The switching period therefore always lies between two limits.

Within each on-time, the current-sense flag is ignored for a short leading-edge interval. After that interval a trip ends the pulse. The pulse also ends at a maximum on-time whatever the flag does. All intervals are parameters counted in clock cycles. The sync input passes through a two-flop synchroniser, and its latency is taken out of the valley delay count.

Top module: `vst_valley_timer`

## Requirements
Cycle numbering used below: the clock edge on which `gate_on` rises is edge 0. Cycle c is the interval between edges c and c+1. The defaults are BLANK_CYC=1875, WIN_CYC=375, SYNC_DLY_CYC=38, LEB_CYC=25 and MAXON_CYC=1500.

- R1: While `en` is sampled low, `gate_on` is low from the next edge on. No turn-on happens while `en` stays low, whatever `sync_hi` does and however long the wait.
- R2: The first clock edge at which `en` is sampled high, after reset or after `en` was low, raises `gate_on` at once.
- R3: A fall of `sync_hi` (high to low) in cycle c is ignored when c+2 < BLANK_CYC or c+2 >= BLANK_CYC+WIN_CYC.
- R4: A fall of `sync_hi` in cycle c with BLANK_CYC <= c+2 < BLANK_CYC+WIN_CYC raises `gate_on` at edge c+SYNC_DLY_CYC, provided that edge comes before edge BLANK_CYC+WIN_CYC.
- R5: If no valley turn-on has happened earlier, `gate_on` rises at edge BLANK_CYC+WIN_CYC.
- R6: `cs_trip` is ignored in cycles c < LEB_CYC. If it is held high from cycle 0, `gate_on` falls at edge LEB_CYC+1.
- R7: If `cs_trip` is high in a cycle c >= LEB_CYC while `gate_on` is high, `gate_on` falls at edge c+1.
- R8: If nothing ends the pulse earlier, `gate_on` falls at edge MAXON_CYC, so a pulse is never longer than MAXON_CYC cycles.
- R9: While `en` stays high, two consecutive turn-ons are at least BLANK_CYC+SYNC_DLY_CYC-2 and at most BLANK_CYC+WIN_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Switching enable; low holds the gate off and clears all timers |
| sync_hi | input | 1 | Sync comparator level, asynchronous (1 = above upper threshold, 0 = below lower threshold) |
| cs_trip | input | 1 | Current-sense comparator flag, 1 = peak current reached |
| gate_on | output | 1 | Gate enable for the power switch, registered |

## Verification
The gate output is a register, so every result appears on an edge counted from the turn-on edge. The bench samples at the falling clock edge, which puts each observation inside a known cycle c. A current-sense trip in cycle c must show at the sample of cycle c+1. A sync fall driven in cycle c must show as a rise at the sample of cycle c+SYNC_DLY_CYC, because the synchroniser's two stages are part of that count. For each period the bench records the first low sample and the next high sample, and compares them with the fall and rise edges it predicts. The stimulus includes window edges one cycle either side, a valley whose delay runs past the forced edge, and trips before, at and after the blanking limit.

// File: rtl/vst_pkg.sv
package vst_pkg;

  // Reason the gate is being switched on this cycle
  typedef enum logic [1:0] {
    TON_NONE   = 2'd0,
    TON_FIRST  = 2'd1,
    TON_VALLEY = 2'd2,
    TON_FORCE  = 2'd3
  } ton_cause_e;

  // Bits needed to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/vst_sync_fall.sv
// Multi-stage synchroniser followed by a high-to-low transition detector.
module vst_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);

  // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its previous value
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], din};
  end

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q[g] <= 1'b0;
        end else begin
          pipe_q[g] <= pipe_d[g];
        end
      end
    end
  endgenerate

  always_comb begin
    fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];
  end

endmodule

// File: rtl/vst_period_ctl.sv
// Period timer: blanking after each turn-on, bounded valley window,
// valley delay and forced turn-on at the window end.
module vst_period_ctl
  import vst_pkg::*;
#(
  parameter int unsigned BLANK_CYC    = 1875,
  parameter int unsigned WIN_CYC      = 375,
  parameter int unsigned SYNC_DLY_CYC = 38,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       valley_fall,
  output ton_cause_e cause
);

  localparam int unsigned MAXPER   = BLANK_CYC + WIN_CYC;
  localparam int unsigned CNT_W    = cnt_width(MAXPER);
  localparam int unsigned DLY_LOAD = SYNC_DLY_CYC - SYNC_STAGES - 2;
  localparam int unsigned DLY_W    = cnt_width(DLY_LOAD);

  localparam logic [CNT_W-1:0] BLANK_V  = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] MAXPER_V = CNT_W'(MAXPER);
  localparam logic [CNT_W-1:0] LAST_V   = CNT_W'(MAXPER - 1);
  localparam logic [DLY_W-1:0] LOAD_V   = DLY_W'(DLY_LOAD);

  logic             started_q, started_d;
  logic [CNT_W-1:0] per_q,     per_d;
  logic             dly_act_q, dly_act_d;
  logic [DLY_W-1:0] dly_q,     dly_d;

  logic win_open;
  logic force_hit;
  logic valley_hit;
  logic fire;
  logic dly_start;

  // Turn-on decision
  always_comb begin
    win_open   = started_q && (per_q >= BLANK_V) && (per_q < MAXPER_V);
    force_hit  = started_q && (per_q == LAST_V);
    valley_hit = dly_act_q && (dly_q == '0);
    if (!en) begin
      cause = TON_NONE;
    end else if (!started_q) begin
      cause = TON_FIRST;
    end else if (valley_hit) begin
      cause = TON_VALLEY;
    end else if (force_hit) begin
      cause = TON_FORCE;
    end else begin
      cause = TON_NONE;
    end
    fire = (cause != TON_NONE);
  end

  // Next state
  always_comb begin
    dly_start = en && started_q && !dly_act_q && !fire && valley_fall && win_open;

    started_d = en;

    if (!en || fire) begin
      per_d = '0;
    end else if (per_q != MAXPER_V) begin
      per_d = per_q + 1'b1;
    end else begin
      per_d = per_q;
    end

    if (!en || fire) begin
      dly_act_d = 1'b0;
    end else if (dly_start) begin
      dly_act_d = 1'b1;
    end else begin
      dly_act_d = dly_act_q;
    end

    if (dly_start) begin
      dly_d = LOAD_V;
    end else if (dly_act_q && (dly_q != '0)) begin
      dly_d = dly_q - 1'b1;
    end else begin
      dly_d = dly_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      per_q     <= '0;
      dly_act_q <= 1'b0;
      dly_q     <= '0;
    end else begin
      started_q <= started_d;
      per_q     <= per_d;
      dly_act_q <= dly_act_d;
      dly_q     <= dly_d;
    end
  end

endmodule

// File: rtl/vst_ontime_ctl.sv
// On-time timer: leading-edge blanking of the current-sense flag,
// pulse-by-pulse trip and maximum on-time.
module vst_ontime_ctl
  import vst_pkg::*;
#(
  parameter int unsigned LEB_CYC   = 25,
  parameter int unsigned MAXON_CYC = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fire,
  input  logic gate,
  input  logic cs_trip,
  output logic off_req
);

  localparam int unsigned OT_W = cnt_width(MAXON_CYC);

  localparam logic [OT_W-1:0] LEB_V  = OT_W'(LEB_CYC);
  localparam logic [OT_W-1:0] LAST_V = OT_W'(MAXON_CYC - 1);

  logic [OT_W-1:0] ot_q, ot_d;
  logic            leb_done;
  logic            cap_hit;

  always_comb begin
    leb_done = (ot_q >= LEB_V);
    cap_hit  = (ot_q == LAST_V);
    off_req  = gate && ((leb_done && cs_trip) || cap_hit);
  end

  always_comb begin
    if (!en || fire) begin
      ot_d = '0;
    end else if (gate && !cap_hit) begin
      ot_d = ot_q + 1'b1;
    end else begin
      ot_d = ot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_q <= '0;
    end else begin
      ot_q <= ot_d;
    end
  end

endmodule

// File: rtl/vst_valley_timer.sv
// Top: valley-switching turn-on timer with registered gate enable.
module vst_valley_timer
  import vst_pkg::*;
#(
  parameter int unsigned BLANK_CYC    = 1875,
  parameter int unsigned WIN_CYC      = 375,
  parameter int unsigned SYNC_DLY_CYC = 38,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LEB_CYC      = 25,
  parameter int unsigned MAXON_CYC    = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sync_hi,
  input  logic cs_trip,
  output logic gate_on
);

  ton_cause_e cause;
  logic       valley_fall;
  logic       fire;
  logic       off_req;
  logic       gate_q, gate_d;

  vst_sync_fall #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sync_hi),
    .fall  (valley_fall)
  );

  vst_period_ctl #(
    .BLANK_CYC    (BLANK_CYC),
    .WIN_CYC      (WIN_CYC),
    .SYNC_DLY_CYC (SYNC_DLY_CYC),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_period (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .valley_fall (valley_fall),
    .cause       (cause)
  );

  always_comb begin
    fire = (cause != TON_NONE);
  end

  vst_ontime_ctl #(
    .LEB_CYC   (LEB_CYC),
    .MAXON_CYC (MAXON_CYC)
  ) u_ontime (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .fire    (fire),
    .gate    (gate_q),
    .cs_trip (cs_trip),
    .off_req (off_req)
  );

  always_comb begin
    if (!en) begin
      gate_d = 1'b0;
    end else if (fire) begin
      gate_d = 1'b1;
    end else if (off_req) begin
      gate_d = 1'b0;
    end else begin
      gate_d = gate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign gate_on = gate_q;

endmodule

// File: rtl/vst_valley_timer_chk.sv
// Property checker, attached to the top module with bind.
module vst_valley_timer_chk #(
  parameter int unsigned BLANK_CYC    = 1875,
  parameter int unsigned WIN_CYC      = 375,
  parameter int unsigned SYNC_DLY_CYC = 38,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LEB_CYC      = 25,
  parameter int unsigned MAXON_CYC    = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic gate_on
);

  localparam logic [31:0] MAXPER  = 32'(BLANK_CYC + WIN_CYC);
  localparam logic [31:0] MINPER  = 32'(BLANK_CYC + SYNC_DLY_CYC - SYNC_STAGES);
  localparam logic [31:0] LEB_MIN = 32'(LEB_CYC + 1);
  localparam logic [31:0] MAXON_V = 32'(MAXON_CYC);
  localparam logic [31:0] SAT_V   = 32'hFFFF_FFFF;

  logic        gate_prev;
  logic        seen_rise;
  logic [31:0] hi_cnt;
  logic [31:0] gap_cnt;
  logic        rise_now;

  always_comb begin
    rise_now = gate_on && !gate_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_prev <= 1'b0;
      seen_rise <= 1'b0;
      hi_cnt    <= '0;
      gap_cnt   <= '0;
    end else begin
      gate_prev <= gate_on;
      if (!en) begin
        seen_rise <= 1'b0;
      end else if (rise_now) begin
        seen_rise <= 1'b1;
      end
      hi_cnt <= gate_on ? hi_cnt + 1'b1 : '0;
      if (rise_now) begin
        gap_cnt <= 32'd1;
      end else if (gap_cnt != SAT_V) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_on); // R1

  AST_FIRST_ON_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> gate_on); // R2

  AST_LEB_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_on) && $past(en)) |-> (hi_cnt >= LEB_MIN)); // R6

  AST_ONTIME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= MAXON_V); // R8

  AST_PERIOD_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && seen_rise) |-> (gap_cnt <= MAXPER)); // R5

  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && seen_rise) |-> (gap_cnt >= MINPER)); // R9

endmodule

bind vst_valley_timer vst_valley_timer_chk #(
  .BLANK_CYC    (BLANK_CYC),
  .WIN_CYC      (WIN_CYC),
  .SYNC_DLY_CYC (SYNC_DLY_CYC),
  .SYNC_STAGES  (SYNC_STAGES),
  .LEB_CYC      (LEB_CYC),
  .MAXON_CYC    (MAXON_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .gate_on (gate_on)
);

// File: tb/vst_valley_timer_tb.sv
module vst_valley_timer_tb;

  localparam int BLANK  = 1875;
  localparam int WIN    = 375;
  localparam int DLY    = 38;
  localparam int LEB    = 25;
  localparam int MAXON  = 1500;
  localparam int MAXPER = BLANK + WIN;
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic sync_hi = 1'b0;
  logic cs_trip = 1'b0;
  logic gate_on;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  vst_valley_timer #(
    .BLANK_CYC    (BLANK),
    .WIN_CYC      (WIN),
    .SYNC_DLY_CYC (DLY),
    .SYNC_STAGES  (2),
    .LEB_CYC      (LEB),
    .MAXON_CYC    (MAXON)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .sync_hi (sync_hi),
    .cs_trip (cs_trip),
    .gate_on (gate_on)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected fall edge of the pulse (R6, R7, R8)
  function automatic int exp_width(input int tc);
    int w;
    if (tc < 0) return MAXON;
    w = ((tc > LEB) ? tc : LEB) + 1;
    return (w > MAXON) ? MAXON : w;
  endfunction

  // Expected next turn-on edge (R3, R4, R5)
  function automatic int exp_period(input int vc);
    int p;
    if (vc >= 1 && vc + 2 >= BLANK && vc + 2 < MAXPER) begin
      p = vc + DLY;
      return (p > MAXPER) ? MAXPER : p;
    end
    return MAXPER;
  endfunction

  function automatic string width_tag(input int tc);
    if (tc < 0 || tc >= MAXON) return "R8 max on-time";
    if (tc < LEB) return "R6 leading-edge blanking";
    return "R7 current trip";
  endfunction

  function automatic string period_tag(input int vc);
    if (vc >= 1 && vc + 2 < BLANK) return "R3 fall during blanking ignored";
    if (vc >= 1 && vc + 2 >= MAXPER) return "R3 fall after window ignored";
    if (vc >= 1 && vc + DLY < MAXPER) return "R4 valley turn-on";
    return "R5 forced turn-on";
  endfunction

  // Entered at the falling edge in cycle 0 of a period (gate just rose).
  // vc: cycle in which sync_hi falls (-1 = stays low). tc: first trip cycle (-1 = none).
  task automatic run_period(input int vc, input int tc);
    int fall_c;
    int rise_c;
    fall_c = -1;
    rise_c = -1;
    sync_hi = (vc > 0);
    cs_trip = (tc == 0);
    for (int c = 1; c <= MAXPER + 8; c++) begin
      @(negedge clk);
      if (fall_c < 0 && !gate_on) begin
        fall_c = c;
      end else if (fall_c >= 0 && gate_on) begin
        rise_c = c;
        break;
      end
      sync_hi = (vc > 0 && c < vc);
      cs_trip = (fall_c < 0 && tc >= 0 && c >= tc);
    end
    cs_trip = 1'b0;
    check(width_tag(tc), fall_c, exp_width(tc));
    check(period_tag(vc), rise_c, exp_period(vc));
  endtask

  // Hold en low for n cycles while toggling sync_hi; count gate highs (R1)
  task automatic hold_disabled(input int n);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate_on) highs++;
      sync_hi = i[4];
    end
    sync_hi = 1'b0;
    check("R1 no turn-on while disabled", highs, 0);
  endtask

  initial begin
    int unsigned seed;
    int vc;
    int tc;
    seed = $urandom(32'd4242);

    repeat (4) @(negedge clk);
    check("R1 gate low in reset", int'(gate_on), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 gate low with en low", int'(gate_on), 0);
    hold_disabled(MAXPER + 20);

    en = 1'b1;
    @(negedge clk);
    check("R2 first turn-on immediate", int'(gate_on), 1);

    // Directed corner cases
    run_period(-1, -1);              // no valley, no trip
    run_period(BLANK - 2, 0);        // first valid valley cycle, trip inside blanking
    run_period(BLANK - 3, LEB);      // fall one cycle early, trip at LEB limit
    run_period(MAXPER - 3, LEB - 1); // valid valley but delay passes forced edge
    run_period(BLANK + 100, LEB + 40);
    run_period(MAXPER - DLY, MAXON - 1);
    run_period(MAXPER - 2, -1);      // fall one cycle past window
    run_period(20, 3);               // early fall in blanking

    // Disable in cycle 0 of a pulse
    en = 1'b0;
    @(negedge clk);
    check("R1 gate drops when disabled", int'(gate_on), 0);
    hold_disabled(MAXPER + 40);
    en = 1'b1;
    @(negedge clk);
    check("R2 turn-on after re-enable", int'(gate_on), 1);

    // Random periods
    for (int k = 0; k < 24; k++) begin
      vc = ($urandom_range(0, 7) == 0) ? -1 : BLANK - 40 + int'($urandom_range(0, WIN + 60));
      tc = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, MAXON + 20));
      run_period(vc, tc);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait (cyc >= WDOG);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=%0d expected=<%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule